// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by walking a two-level translation structure kept in memory. A base register, written through its own port, gives the 4 KB-aligned physical location of a 1024-entry directory. For each request the walker fetches one directory entry and then one table entry through a single-word memory port. It checks the present, write and user permissions and, when the access is allowed, returns the page frame joined with the page offset.

A walk that succeeds sets the accessed bit in both entries and, for a write, the dirty bit in the table entry. Only entries whose value changes are written back. A walk that fails returns a three-bit error code and stores the faulting linear address in a fault-address register. Every write to the base register raises a one-cycle pulse that tells any translation cache to drop its contents.

Top module: `page_walker`

## Requirements
- R1: The linear address splits into a directory index (bits 31:22), a table index (bits 21:12) and an offset (bits 11:0). The first read goes to {base[31:12], dir index, 2'b00} and the second read goes to {directory entry bits 31:12, table index, 2'b00}.
- R2: A write to the base register keeps only bits 31:12 of the written value and clears the low 12 bits. `flush` is high for exactly the one cycle after each such write.
- R3: If bit 0 (present) of the directory entry or of the table entry is clear, the walk faults with error code bit 0 = 0. If the directory entry is not present, the table entry is never read.
- R4: At privilege level 3, the walk faults unless bit 2 (user) is set in both entries. At levels 0 to 2, the user bit is not checked.
- R5: A write access faults unless bit 1 (writable) is set in both entries. This check applies at level 3. It applies at levels 0 to 2 only while `wp_en` was high when the request was accepted. A permission fault gives error code bit 0 = 1.
- R6: On every fault, error code bit 1 equals the write flag of the request, and bit 2 is 1 for level 3 and 0 for levels 0 to 2.
- R7: On a fault, `fault_addr` takes the request's linear address. It keeps that value through later walks that succeed.
- R8: A successful walk returns `paddr` = {table entry bits 31:12, offset} with `fault` low. `done` is high for exactly one cycle at the end of every walk.
- R9: After a successful walk, bit 5 (accessed) is set in both entries, and bit 6 (dirty) is set in the table entry when the access is a write. All other bits are kept. An entry is written back only if its value changes, and a faulting walk writes nothing.
- R10: `busy` is high from the cycle after a request is accepted until `done`. Requests presented while `busy` is high are ignored.
- R11: Read data is taken the cycle after `mem_rd`. `mem_rd` and `mem_wr` are never high together.
- R12: After reset the walker is idle: `busy`, `done`, `fault`, `flush` and the memory strobes are low, and `fault_addr` and the base register are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Write strobe for the base register |
| base_wdata | input | 32 | Value written to the base register |
| flush | output | 1 | One-cycle pulse telling a translation cache to discard its contents |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_addr | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 = write access |
| req_cpl | input | 2 | Current privilege level (3 = user) |
| wp_en | input | 1 | Apply the write check at privilege levels 0 to 2 |
| busy | output | 1 | Walk in progress |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory word address (byte units) |
| mem_wdata | output | 32 | Entry value written back |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |
| done | output | 1 | Walk finished (one cycle) |
| fault | output | 1 | Walk ended in a fault (valid with `done`) |
| err_code | output | 3 | {user mode, write, protection} |
| paddr | output | 32 | Translated physical address |
| fault_addr | output | 32 | Linear address of the last fault |

## Verification
The assertions check the following on every cycle:
- the read and write strobes never overlap;
- the flush pulse follows each base write;
- `done` lasts one cycle;
- every write-back carries the accessed bit;
- the first read after a request targets the right directory slot;
- fault codes, the fault address and the page offset agree with what the request carried.

Other behaviour can only be shown by the bench's scenarios. These are the full permission decision over every combination of present, user, writable, accessed and dirty bits, privilege level, access direction and write protection; which entries are written back and with what values; base alignment; and ignoring requests while busy.

// File: rtl/page_walker.sv
module page_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        base_we,
  input  logic [31:0] base_wdata,
  output logic        flush,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic        req_write,
  input  logic [1:0]  req_cpl,
  input  logic        wp_en,
  output logic        busy,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        done,
  output logic        fault,
  output logic [2:0]  err_code,
  output logic [31:0] paddr,
  output logic [31:0] fault_addr
);
  localparam int B_P = 0, B_W = 1, B_U = 2, B_A = 5, B_D = 6;

  typedef enum logic [2:0] {S_IDLE, S_RDD, S_LDD, S_RDT, S_LDT, S_CHK, S_WBD, S_WBT} st_t;
  st_t state;

  logic [31:0] base, la, pde, pte;
  logic        wr_q, usr_q, wp_q;

  wire [31:0] dir_ptr = {base[31:12], la[31:22], 2'b00};
  wire [31:0] tbl_ptr = {pde[31:12], la[21:12], 2'b00};
  wire [31:0] pde_new = pde | (32'd1 << B_A);
  wire [31:0] pte_new = pte | (32'd1 << B_A) | (wr_q ? (32'd1 << B_D) : 32'd0);
  wire need_d = pde_new != pde;
  wire need_t = pte_new != pte;

  wire u_ok = !usr_q || (pde[B_U] && pte[B_U]);
  wire w_ok = !wr_q || (pde[B_W] && pte[B_W]) || (!usr_q && !wp_q);
  wire prot = !(u_ok && w_ok);

  wire go_flt = ((state == S_LDD || state == S_LDT) && !mem_rdata[B_P]) ||
                (state == S_CHK && prot);
  wire go_ok  = (state == S_CHK && !prot && !need_d && !need_t) ||
                (state == S_WBD && !need_t) || (state == S_WBT);

  assign busy      = state != S_IDLE;
  assign mem_rd    = state == S_RDD || state == S_RDT;
  assign mem_wr    = state == S_WBD || state == S_WBT;
  assign mem_addr  = (state == S_RDD || state == S_WBD) ? dir_ptr : tbl_ptr;
  assign mem_wdata = (state == S_WBD) ? pde_new : pte_new;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      base       <= '0;
      flush      <= 1'b0;
      done       <= 1'b0;
      fault      <= 1'b0;
      err_code   <= '0;
      paddr      <= '0;
      fault_addr <= '0;
      la         <= '0;
      pde        <= '0;
      pte        <= '0;
      wr_q       <= 1'b0;
      usr_q      <= 1'b0;
      wp_q       <= 1'b0;
    end else begin
      flush <= base_we;
      if (base_we) base <= {base_wdata[31:12], 12'h000};
      done <= go_ok || go_flt;
      if (go_flt) begin
        fault      <= 1'b1;
        err_code   <= {usr_q, wr_q, state == S_CHK};
        fault_addr <= la;
      end else if (go_ok) begin
        fault    <= 1'b0;
        err_code <= '0;
        paddr    <= {pte[31:12], la[11:0]};
      end
      unique case (state)
        S_IDLE: if (req_valid) begin
          la    <= req_addr;
          wr_q  <= req_write;
          usr_q <= req_cpl == 2'd3;
          wp_q  <= wp_en;
          state <= S_RDD;
        end
        S_RDD: state <= S_LDD;
        S_LDD: begin
          pde   <= mem_rdata;
          state <= mem_rdata[B_P] ? S_RDT : S_IDLE;
        end
        S_RDT: state <= S_LDT;
        S_LDT: begin
          pte   <= mem_rdata;
          state <= mem_rdata[B_P] ? S_CHK : S_IDLE;
        end
        S_CHK: state <= prot ? S_IDLE : need_d ? S_WBD : need_t ? S_WBT : S_IDLE;
        S_WBD: state <= need_t ? S_WBT : S_IDLE;
        S_WBT: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/page_walker_chk.sv
module page_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        base_we,
  input logic        flush,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic        req_write,
  input logic [1:0]  req_cpl,
  input logic        busy,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        done,
  input logic        fault,
  input logic [2:0]  err_code,
  input logic [31:0] paddr,
  input logic [31:0] fault_addr
);
  logic [31:0] la_c;
  logic        wr_c, usr_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      la_c  <= '0;
      wr_c  <= 1'b0;
      usr_c <= 1'b0;
    end else if (req_valid && !busy) begin
      la_c  <= req_addr;
      wr_c  <= req_write;
      usr_c <= req_cpl == 2'd3;
    end
  end

  assert_rd_wr_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  assert_flush_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |=> flush);
  assert_flush_only_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> $past(base_we));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_wb_accessed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_wdata[5]);
  assert_dir_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> (mem_rd && mem_addr[11:2] == la_c[31:22]));
  assert_fault_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (err_code[1] == wr_c && err_code[2] == usr_c));
  assert_fault_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> fault_addr == la_c);
  assert_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> paddr[11:0] == la_c[11:0]);
endmodule

bind page_walker page_walker_chk u_chk (.*);

// File: tb/tb_page_walker.sv
module tb_page_walker;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        base_we = 0, req_valid = 0, req_write = 0, wp_en = 0;
  logic [31:0] base_wdata = 0, req_addr = 0;
  logic [1:0]  req_cpl = 0;
  logic        flush, busy, mem_rd, mem_wr, done, fault;
  logic [31:0] mem_addr, mem_wdata, paddr, fault_addr;
  logic [31:0] mem_rdata;
  logic [2:0]  err_code;

  page_walker dut (.*);

  logic [31:0] mem [4096];
  logic        tb_we = 0;
  logic [11:0] tb_idx = 0;
  logic [31:0] tb_val = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [31:0] rd_last = 0, rd_prev = 0;

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= mem[mem_addr[13:2]];
      rd_prev <= rd_last;
      rd_last <= mem_addr;
      rd_cnt <= rd_cnt + 1;
    end
    if (mem_wr) begin
      mem[mem_addr[13:2]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end else if (tb_we) mem[tb_idx] <= tb_val;
  end

  int checks = 0, fails = 0;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [11:0] idx, input logic [31:0] v);
    tb_idx = idx; tb_val = v; tb_we = 1;
    @(negedge clk);
    tb_we = 0;
  endtask

  task automatic walk(input logic [31:0] a, input logic w, input logic [1:0] c, input logic wp);
    int t = 0;
    req_addr = a; req_write = w; req_cpl = c; wp_en = wp; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    while (!done && t < 50) begin @(negedge clk); t++; end
    if (!done) chk("watchdog R8", 0, 1);
  endtask

  logic [31:0] base_now = 0;

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 busy", busy, 0);
    chk("R12 done", done, 0);
    chk("R12 flush", flush, 0);
    chk("R12 fault_addr", fault_addr, 0);
    chk("R12 strobes", {mem_rd, mem_wr}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int k = 0; k < 4096; k++) begin
      logic pP, pW, pU, pA, tP, tW, tU, tA, tD, w, u, wp;
      logic [9:0] di, ti;
      logic [11:0] off;
      logic [31:0] pde, pte, la, exp_pde, exp_pte;
      logic exp_f, exp_p, uok, wok;
      int w0, r0, exp_w, exp_r;
      {pP, pW, pU, pA, tP, tW, tU, tA, tD, w, u, wp} = k[11:0];
      di = k[9:0] ^ 10'h155;
      ti = 10'((k * 37) % 1024);
      off = 12'((k * 13) % 4096);
      la = {di, ti, off};
      pde = {20'h00001, 5'b0, 1'b0, pA, k[0], k[1], pU, pW, pP};
      pte = {20'h80000 + 20'(k), 5'b0, tD, tA, k[2], k[3], tU, tW, tP};
      poke({2'b00, di}, pde);
      poke({2'b01, ti}, pte);
      w0 = wr_cnt; r0 = rd_cnt;
      walk(la, w, u ? 2'd3 : 2'(k % 3), wp);
      uok = !u || (pU && tU);
      wok = !w || (pW && tW) || (!u && !wp);
      exp_f = !pP || !tP || !(uok && wok);
      exp_p = pP && tP;
      exp_r = pP ? 2 : 1;
      exp_pde = pde; exp_pte = pte; exp_w = 0;
      if (!exp_f) begin
        exp_pde = pde | 32'h20;
        exp_pte = pte | 32'h20 | (w ? 32'h40 : 0);
        exp_w = (exp_pde != pde ? 1 : 0) + (exp_pte != pte ? 1 : 0);
      end
      chk("R3 R4 R5 fault", fault, exp_f);
      chk("R1 read count", rd_cnt - r0, exp_r);
      if (pP) chk("R1 table read addr", rd_last, {20'h00001, ti, 2'b00});
      chk("R1 dir read addr", pP ? rd_prev : rd_last, {20'h00000, di, 2'b00});
      if (exp_f) begin
        chk("R6 err_code", err_code, {u, w, exp_p});
        chk("R7 fault_addr", fault_addr, la);
      end else
        chk("R8 paddr", paddr, {20'h80000 + 20'(k), off});
      chk("R9 write count", wr_cnt - w0, exp_w);
      chk("R9 dir entry", mem[{2'b00, di}], exp_pde);
      chk("R9 table entry", mem[{2'b01, ti}], exp_pte);
      @(negedge clk);
      if (k % 64 == 0) chk("R8 done one cycle", done, 0);
    end

    base_wdata = 32'h0000_2ABC; base_we = 1;
    @(negedge clk);
    base_we = 0;
    chk("R2 flush pulse", flush, 1);
    @(negedge clk);
    chk("R2 flush low", flush, 0);
    poke(12'h800 | 12'd5, 32'h0000_1007);
    poke(12'h400 | 12'd9, 32'h1234_5007);
    walk({10'd5, 10'd9, 12'hABC}, 0, 0, 0);
    chk("R2 aligned base read", rd_prev, 32'h0000_2000 | (5 << 2));
    chk("R2 paddr", paddr, 32'h1234_5ABC);

    fault_addr_check: begin
      logic [31:0] fa;
      poke(12'h800 | 12'd6, 32'h0000_1000);
      walk({10'd6, 10'd1, 12'h010}, 1, 3, 0);
      chk("R3 not present", {fault, err_code}, {1'b1, 3'b110});
      fa = fault_addr;
      chk("R7 latch", fa, {10'd6, 10'd1, 12'h010});
      walk({10'd5, 10'd9, 12'h001}, 0, 0, 0);
      chk("R7 hold", fault_addr, fa);
    end

    req_addr = {10'd5, 10'd9, 12'h111}; req_write = 0; req_cpl = 0; req_valid = 1;
    @(negedge clk);
    chk("R10 busy", busy, 1);
    req_addr = {10'd6, 10'd1, 12'h222};
    @(negedge clk);
    req_valid = 0;
    begin
      int t = 0;
      while (!done && t < 50) begin @(negedge clk); t++; end
    end
    chk("R10 ignored request", paddr, 32'h1234_5111);
    repeat (3) @(negedge clk);
    chk("R10 no second walk", busy, 0);
    chk("R11 exclusive strobes", mem_rd & mem_wr, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog R8 actual=hung expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule